// File: doc/BRIEF.md
# Dual-Clock Queue with Direct Output Path

This block is a first-in first-out data queue that crosses between two unrelated clocks. A producer writes words on the write clock and a consumer takes them from a registered output on the read clock. Each side has two enable pins, and a side acts only when both of its pins are high. A producer can drive one pin from its own logic and tie the other to a partner's status. The queue holds a full flag in the write domain and an empty flag in the read domain. Each flag comes from the other side's pointer, which crosses as a Gray code through two flip-flops.

The active-low `bypass_n` pin selects a direct path. While it is low, the input word appears on `data_out` with no register on the way, so data passes straight across without a queue write and a later read. Bypass changes nothing that the queue holds. The enables keep their normal meaning during bypass. An enabled write still stores the input word. An enabled read loads the input word into the output register and still advances the read pointer past the word at the head of the queue. The output-enable pin works in both modes.

The interface has no valid/ready handshake. Back-pressure is shown by the flags. A write attempted while `full` is high is dropped, and a read attempted while `empty` is high leaves the output register and the read pointer unchanged. The caller has to watch the flags. The usual idle setting for bypass is to hold all four enables low, so that only the direct path is active.

Top module: `bypass_queue`

## Requirements
- R1: A write happens only on a rising `wclk` edge where `wen_a` and `wen_b` are both high. A read happens only on a rising `rclk` edge where `ren_a` and `ren_b` are both high. With one pin of a pair low, that side does nothing.
- R2: `full` is high once DEPTH words are stored and not yet read. A write attempted while `full` is high stores nothing and does not move the write pointer.
- R3: `empty` is high when no unread word is stored. A read attempted while `empty` is high changes neither `data_out` nor the read pointer.
- R4: Words leave in the order they were written. A read in normal mode (`bypass_n` high) puts the head word on `data_out` after that `rclk` edge.
- R5: While `bypass_n` is low and `oe` is high, `data_out` equals `din` with no clock edge in between.
- R6: Entering and leaving bypass with all enables low does not change the stored words, their order or the flags.
- R7: A write enabled during bypass stores `din` in the queue, exactly as in normal mode.
- R8: A read enabled during bypass loads `din` into the output register. If the queue is not empty, that read also advances the read pointer past the head word, and the head word is lost. After the return to normal mode, `data_out` shows the loaded word.
- R9: While `oe` is low, `data_out` is all zeros in both modes. `oe` changes no state.
- R10: After `rst_n` is asserted, `empty` is 1, `full` is 0 and the output register holds zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| din | input | WIDTH | Input word |
| wen_a | input | 1 | Write enable, first of pair |
| wen_b | input | 1 | Write enable, second of pair |
| ren_a | input | 1 | Read enable, first of pair |
| ren_b | input | 1 | Read enable, second of pair |
| bypass_n | input | 1 | Low selects the direct input-to-output path |
| oe | input | 1 | High drives the data output, low forces it to zero |
| data_out | output | WIDTH | Output word |
| full | output | 1 | Queue full, write domain |
| empty | output | 1 | Queue empty, read domain |

## Verification
The hardest case is bypass with both ports enabled on the same pair of clock edges. In that case one input word is both stored in the queue and loaded into the output register, while the read pointer steps over the old head word. The bench sets this up from a queue holding one known word. It fires a write and a read together during bypass and then leaves bypass. It expects the loaded word on the output, and the same word again as the only entry left in the queue, after which the queue must be empty. A separate sweep fills the queue to every count from zero to full and checks the flags and the order of the words. It also adds a blocked write at full and a blocked read at empty.

// File: rtl/bypass_queue_pkg.sv
package bypass_queue_pkg;

  // Source that drives the data output pins
  typedef enum logic [1:0] {
    SRC_OFF    = 2'd0,
    SRC_QUEUE  = 2'd1,
    SRC_DIRECT = 2'd2
  } out_src_e;

  localparam int unsigned SYNC_STAGES = 2;

endpackage

// File: rtl/bq_sync.sv
// Multi-flop synchronizer for a Gray-coded pointer bus
module bq_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '0;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/bq_mem.sv
// Storage: one write port on the write clock, unclocked read port
module bq_mem #(
  parameter int unsigned WIDTH = 36,
  parameter int unsigned DEPTH = 1024,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic             wclk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] cells [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];

endmodule

// File: rtl/bq_wr_ctrl.sv
// Write pointer, Gray image and full detection
module bq_wr_ctrl #(
  parameter int unsigned AW = 10
) (
  input  logic        wclk,
  input  logic        rst_n,
  input  logic        req,
  input  logic [AW:0] rd_gray_sync,
  output logic [AW:0] wr_bin,
  output logic [AW:0] wr_gray,
  output logic        full,
  output logic        fire
);

  logic [AW:0] bin_nxt;
  logic [AW:0] far_side;

  // Full: pointers differ only in the wrap bit (top two Gray bits inverted)
  assign far_side = {~rd_gray_sync[AW:AW-1], rd_gray_sync[AW-2:0]};
  assign full     = (wr_gray == far_side);
  assign fire     = req & ~full;
  assign bin_nxt  = wr_bin + {{AW{1'b0}}, fire};

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      wr_bin  <= '0;
      wr_gray <= '0;
    end else begin
      wr_bin  <= bin_nxt;
      wr_gray <= bin_nxt ^ (bin_nxt >> 1);
    end
  end

endmodule

// File: rtl/bq_rd_ctrl.sv
// Read pointer, Gray image and empty detection
module bq_rd_ctrl #(
  parameter int unsigned AW = 10
) (
  input  logic        rclk,
  input  logic        rst_n,
  input  logic        req,
  input  logic [AW:0] wr_gray_sync,
  output logic [AW:0] rd_bin,
  output logic [AW:0] rd_gray,
  output logic        empty,
  output logic        fire
);

  logic [AW:0] bin_nxt;

  assign empty   = (rd_gray == wr_gray_sync);
  assign fire    = req & ~empty;
  assign bin_nxt = rd_bin + {{AW{1'b0}}, fire};

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rd_bin  <= '0;
      rd_gray <= '0;
    end else begin
      rd_bin  <= bin_nxt;
      rd_gray <= bin_nxt ^ (bin_nxt >> 1);
    end
  end

endmodule

// File: rtl/bypass_queue.sv
// Dual-clock queue with an active-low direct path to the output
module bypass_queue
  import bypass_queue_pkg::*;
#(
  parameter int unsigned WIDTH = 36,
  parameter int unsigned DEPTH = 1024
) (
  input  logic             wclk,
  input  logic             rclk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  input  logic             wen_a,
  input  logic             wen_b,
  input  logic             ren_a,
  input  logic             ren_b,
  input  logic             bypass_n,
  input  logic             oe,
  output logic [WIDTH-1:0] data_out,
  output logic             full,
  output logic             empty
);

  localparam int unsigned AW = $clog2(DEPTH);

  logic          wr_req, rd_req;
  logic          wr_fire, rd_fire;
  logic [AW:0]   wr_bin, wr_gray, rd_bin, rd_gray;
  logic [AW:0]   wr_gray_rs, rd_gray_ws;
  logic [WIDTH-1:0] mem_rdata;
  logic [WIDTH-1:0] out_reg;
  out_src_e      src;

  // A side acts only when both of its enables are high
  assign wr_req = wen_a & wen_b;
  assign rd_req = ren_a & ren_b;

  bq_wr_ctrl #(.AW(AW)) u_wr (
    .wclk         (wclk),
    .rst_n        (rst_n),
    .req          (wr_req),
    .rd_gray_sync (rd_gray_ws),
    .wr_bin       (wr_bin),
    .wr_gray      (wr_gray),
    .full         (full),
    .fire         (wr_fire)
  );

  bq_rd_ctrl #(.AW(AW)) u_rd (
    .rclk         (rclk),
    .rst_n        (rst_n),
    .req          (rd_req),
    .wr_gray_sync (wr_gray_rs),
    .rd_bin       (rd_bin),
    .rd_gray      (rd_gray),
    .empty        (empty),
    .fire         (rd_fire)
  );

  bq_sync #(.W(AW+1), .STAGES(SYNC_STAGES)) u_sync_w2r (
    .clk   (rclk),
    .rst_n (rst_n),
    .d     (wr_gray),
    .q     (wr_gray_rs)
  );

  bq_sync #(.W(AW+1), .STAGES(SYNC_STAGES)) u_sync_r2w (
    .clk   (wclk),
    .rst_n (rst_n),
    .d     (rd_gray),
    .q     (rd_gray_ws)
  );

  bq_mem #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_mem (
    .wclk  (wclk),
    .we    (wr_fire),
    .waddr (wr_bin[AW-1:0]),
    .wdata (din),
    .raddr (rd_bin[AW-1:0]),
    .rdata (mem_rdata)
  );

  // Output register: loads the head word normally, the input word in bypass.
  // The read pointer is advanced by u_rd in both modes.
  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      out_reg <= '0;
    end else if (rd_req) begin
      if (!bypass_n)    out_reg <= din;
      else if (rd_fire) out_reg <= mem_rdata;
    end
  end

  always_comb begin
    if (!oe)            src = SRC_OFF;
    else if (!bypass_n) src = SRC_DIRECT;
    else                src = SRC_QUEUE;
  end

  always_comb begin
    unique case (src)
      SRC_DIRECT: data_out = din;
      SRC_QUEUE:  data_out = out_reg;
      default:    data_out = '0;
    endcase
  end

endmodule

// File: rtl/bq_checker.sv
// Property checker attached to bypass_queue
module bq_checker #(
  parameter int unsigned WIDTH = 36,
  parameter int unsigned AW    = 10
) (
  input logic             wclk,
  input logic             rclk,
  input logic             rst_n,
  input logic             full,
  input logic             empty,
  input logic [AW:0]      wr_bin,
  input logic [AW:0]      rd_bin,
  input logic [AW:0]      wr_gray,
  input logic             bypass_n,
  input logic             oe,
  input logic [WIDTH-1:0] din,
  input logic [WIDTH-1:0] data_out
);

  AST_FULL_HOLDS_WPTR: assert property (@(posedge wclk) disable iff (!rst_n)
    full |=> $stable(wr_bin)); // R2

  AST_EMPTY_HOLDS_RPTR: assert property (@(posedge rclk) disable iff (!rst_n)
    empty |=> $stable(rd_bin)); // R3

  AST_WPTR_STEP: assert property (@(posedge wclk) disable iff (!rst_n)
    1'b1 |=> (wr_bin == $past(wr_bin)) || (wr_bin == $past(wr_bin) + 1'b1)); // R1

  AST_WGRAY_ONE_BIT: assert property (@(posedge rclk) disable iff (!rst_n)
    $countones(wr_gray ^ $past(wr_gray)) <= 1); // R4

  AST_DIRECT_PATH: assert property (@(posedge rclk) disable iff (!rst_n)
    (!bypass_n && oe) |-> (data_out == din)); // R5

  AST_OE_LOW_ZERO: assert property (@(posedge rclk) disable iff (!rst_n)
    !oe |-> (data_out == '0)); // R9

  AST_FLAGS_RESET: assert property (@(posedge wclk) disable iff (!rst_n)
    $rose(rst_n) |-> !full); // R10

endmodule

bind bypass_queue bq_checker #(.WIDTH(WIDTH), .AW(AW)) u_chk (
  .wclk     (wclk),
  .rclk     (rclk),
  .rst_n    (rst_n),
  .full     (full),
  .empty    (empty),
  .wr_bin   (wr_bin),
  .rd_bin   (rd_bin),
  .wr_gray  (wr_gray),
  .bypass_n (bypass_n),
  .oe       (oe),
  .din      (din),
  .data_out (data_out)
);

// File: tb/bypass_queue_tb.sv
`timescale 1ns/1ps
module bypass_queue_tb;

  localparam int W = 8;
  localparam int D = 8;

  logic         wclk = 0, rclk = 0, rst_n = 0;
  logic [W-1:0] din = '0;
  logic         wen_a = 0, wen_b = 0, ren_a = 0, ren_b = 0;
  logic         bypass_n = 1, oe = 1;
  logic [W-1:0] data_out;
  logic         full, empty;

  int n_chk = 0, n_bad = 0;

  bypass_queue #(.WIDTH(W), .DEPTH(D)) u_dut (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .din(din),
    .wen_a(wen_a), .wen_b(wen_b), .ren_a(ren_a), .ren_b(ren_b),
    .bypass_n(bypass_n), .oe(oe), .data_out(data_out),
    .full(full), .empty(empty)
  );

  always #2 wclk = ~wclk;
  initial begin #1; forever #2 rclk = ~rclk; end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [W-1:0] d, input logic a = 1, input logic b = 1);
    @(negedge wclk); din = d; wen_a = a; wen_b = b;
    @(negedge wclk); wen_a = 0; wen_b = 0;
  endtask

  task automatic rd(input logic a = 1, input logic b = 1);
    @(negedge rclk); ren_a = a; ren_b = b;
    @(negedge rclk); ren_a = 0; ren_b = 0;
  endtask

  task automatic settle();
    repeat (8) @(negedge rclk);
  endtask

  function automatic logic [W-1:0] pat(input int k, input int i);
    return W'((k * 37 + i * 11 + 5) & 8'hFF);
  endfunction

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [W-1:0] last;
    repeat (4) @(negedge wclk);
    rst_n = 1;
    settle();
    // R10 reset state
    check("R10 empty", empty, 1);
    check("R10 full", full, 0);
    check("R10 data_out", data_out, 0);

    // R1: single enable on either side does nothing
    wr(8'hA5, 1, 0); wr(8'hA5, 0, 1); wr(8'hA5, 0, 0);
    settle();
    check("R1 write with one enable", empty, 1);

    // R2 R3 R4: sweep every fill level
    last = '0;
    for (int k = 0; k <= D; k++) begin
      for (int i = 0; i < k; i++) wr(pat(k, i));
      settle();
      check("R2 full at level", full, (k == D) ? 1 : 0);
      check("R3 empty at level", empty, (k == 0) ? 1 : 0);
      if (k == D) begin
        wr(8'hEE); // blocked: R2
        settle();
        check("R2 still full", full, 1);
      end
      if (k == 1) begin
        rd(1, 0); // R1: one read enable only
        check("R1 read with one enable", data_out, last);
      end
      for (int i = 0; i < k; i++) begin
        rd();
        check("R4 order", data_out, pat(k, i));
        last = pat(k, i);
      end
      settle();
      check("R2 R3 empty after drain", empty, 1);
      rd(); // blocked: R3
      check("R3 read while empty holds output", data_out, last);
    end
    // blocked read did not move pointer: next word read is correct
    wr(8'h3C); settle(); rd();
    check("R3 pointer unmoved", data_out, 8'h3C);

    // R5 R6 R9: bypass with enables low
    wr(8'h11); wr(8'h22); wr(8'h33); settle();
    @(negedge rclk); bypass_n = 0;
    for (int d = 0; d < 256; d++) begin
      din = W'(d); #0.5;
      check("R5 direct path", data_out, d);
    end
    oe = 0; #0.5;
    check("R9 oe low in bypass", data_out, 0);
    oe = 1;
    @(negedge rclk); bypass_n = 1; settle();
    check("R6 flags kept", empty, 0);
    rd(); check("R6 word 0", data_out, 8'h11);
    oe = 0; #0.5;
    check("R9 oe low in normal mode", data_out, 0);
    oe = 1; #0.5;
    check("R9 oe keeps state", data_out, 8'h11);
    rd(); check("R6 word 1", data_out, 8'h22);
    rd(); check("R6 word 2", data_out, 8'h33);
    settle(); check("R6 empty", empty, 1);

    // R7: writes during bypass reach the queue
    @(negedge rclk); bypass_n = 0;
    wr(8'h44); wr(8'h55);
    @(negedge rclk); bypass_n = 1; settle();
    rd(); check("R7 word 0", data_out, 8'h44);
    rd(); check("R7 word 1", data_out, 8'h55);

    // R8: read during bypass loads din and skips head
    wr(8'h66); wr(8'h77); settle();
    @(negedge rclk); bypass_n = 0; din = 8'h99;
    rd();
    @(negedge rclk); bypass_n = 1; #0.5;
    check("R8 loaded word", data_out, 8'h99);
    rd(); check("R8 head skipped", data_out, 8'h77);
    settle(); check("R8 empty", empty, 1);

    // R7 R8 together: both ports enabled in the same bypass window
    wr(8'hA1); settle();
    @(negedge rclk); bypass_n = 0; din = 8'hB2;
    fork
      begin @(negedge wclk); wen_a = 1; wen_b = 1; @(negedge wclk); wen_a = 0; wen_b = 0; end
      begin @(negedge rclk); ren_a = 1; ren_b = 1; @(negedge rclk); ren_a = 0; ren_b = 0; end
    join
    @(negedge rclk); bypass_n = 1; #0.5;
    check("R8 joint loaded word", data_out, 8'hB2);
    settle();
    check("R7 joint queue not empty", empty, 0);
    rd(); check("R7 joint stored word", data_out, 8'hB2);
    settle(); check("R8 joint empty", empty, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule